// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is a clocked model of the command interpreter found in a parallel NOR flash device. It watches bus write cycles, each made of a write strobe pulse carrying an address and a byte, and picks out the program, sector-erase, erase-suspend and erase-resume command sequences. From these it steps an internal mode: read, programming, sector-erase time-out, erasing, erase-suspended, or programming while suspended.

The embedded program and erase algorithms are stood in for by down-counters whose lengths are parameters. The same applies to the erase time-out window and to the bounded delay before a suspend takes hold during active erasing. The block raises a one-cycle start pulse when a program or an erase phase begins and reports busy while an embedded operation or the time-out runs. It captures the program target address and data, and the sector address of an erase.

A write cycle is seen as the strobe `busWe` going high and then low again. The address is taken from the clock edge that first samples the strobe high. The data is taken, and the command acted on, at the clock edge that first samples it low again.

Top module: `flashCmdDecoder`

## Requirements
- R1: After reset the mode is read (code 0), busy is low and both start pulses are low.
- R2: The writes AAh to address 555h, 55h to 2AAh and A0h to 555h arm programming. The next write starts it: mode becomes programming (code 1) and progStart pulses for one cycle. progAddr holds that write's address as taken at the strobe's leading edge, and progData holds the byte present at its trailing edge.
- R3: A program stays in mode 1 for PROG_CYC cycles and then returns to read.
- R4: Any write that does not match the next expected step of a sequence drops the sequence back to idle, so a following A0h or 30h write starts nothing.
- R5: The writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, then 30h at any address enter the erase time-out (code 2) and capture the address as eraseSector. After TO_CYC cycles the mode becomes erasing (code 3) with an eraseStart pulse. After ERASE_CYC cycles of erasing it returns to read.
- R6: A B0h write during the erase time-out enters suspended (code 4) at once.
- R7: A B0h write while erasing enters suspended SUSP_LAT cycles later, and the erase keeps counting during that delay. If the erase ends first, the mode goes to read.
- R8: B0h and 30h written in read mode have no effect.
- R9: While suspended, only a resume or the program sequence is acted on. Erase sequences and further B0h writes leave the mode at suspended.
- R10: A 30h write while suspended, from the idle sequence step, returns to erasing with an eraseStart pulse, and the erase resumes from the count it had reached. Suspend and resume may repeat.
- R11: A program started while suspended runs in mode 5 for PROG_CYC cycles and then returns to suspended.
- R12: busy is high in modes 1, 2, 3 and 5 and low in modes 0 and 4.
- R13: Writes made while programming (mode 1 or 5) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWe | input | 1 | Write strobe, high during a write cycle |
| busAddr | input | ADDR_W | Write address, taken at the strobe's leading edge |
| busData | input | 8 | Write data, taken at the strobe's trailing edge |
| mode | output | 3 | 0 read, 1 program, 2 erase time-out, 3 erasing, 4 suspended, 5 program in suspend |
| busy | output | 1 | Embedded operation or time-out in progress |
| progStart | output | 1 | One-cycle pulse when a program begins |
| eraseStart | output | 1 | One-cycle pulse when an erase phase begins or resumes |
| progAddr | output | ADDR_W | Target address of the last program |
| progData | output | 8 | Data of the last program |
| eraseSector | output | ADDR_W | Address of the last sector erase |

## Verification
Every command result lands on the clock edge that first samples the strobe low after a high. Mode, start pulses and captured fields are therefore checked at the falling clock edge that follows, which is where the write task returns. The timed transitions are counted in edges from that point: programming ends PROG_CYC edges on, the time-out hands over to erasing TO_CYC edges on, erasing ends ERASE_CYC edges after that, and a suspend raised while erasing lands SUSP_LAT edges after its write. Each timed check samples one cycle before and one cycle on the due edge. A behavioural reference model also advances on every rising edge and is compared with all outputs at every falling edge.

// File: rtl/flash_cmd_pkg.sv
package flashCmdPkg;

  typedef enum logic [2:0] {
    MD_READ      = 3'd0,
    MD_PROG      = 3'd1,
    MD_ERASE_TO  = 3'd2,
    MD_ERASE     = 3'd3,
    MD_SUSP      = 3'd4,
    MD_SUSP_PROG = 3'd5
  } modeT;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_U1, SQ_U2, SQ_PARM, SQ_E1, SQ_E2, SQ_E3
  } seqT;

  // control -> datapath strobes
  typedef struct packed {
    logic loadProg;
    logic loadErase;
    logic clrTo;
    logic runErase;
    logic loadLat;
    logic clrLat;
    logic capProg;
    logic capSector;
  } strobeT;

  // datapath -> control timer status
  typedef struct packed {
    logic progLast;
    logic toLast;
    logic eraseLast;
    logic latLast;
  } timerT;

  localparam logic [15:0] UNLOCK_ADDR_A = 16'h0555;
  localparam logic [15:0] UNLOCK_ADDR_B = 16'h02AA;
  localparam logic [7:0]  KEY_A         = 8'hAA;
  localparam logic [7:0]  KEY_B         = 8'h55;
  localparam logic [7:0]  OP_PROG       = 8'hA0;
  localparam logic [7:0]  OP_ERASE_SET  = 8'h80;
  localparam logic [7:0]  OP_SECTOR     = 8'h30;
  localparam logic [7:0]  OP_SUSPEND    = 8'hB0;
  localparam logic [7:0]  OP_RESUME     = 8'h30;

endpackage

// File: rtl/flash_down_cnt.sv
module flashDownCnt #(
  parameter int MAX = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic load,
  input  logic clr,
  input  logic en,
  output logic last
);
  localparam int W = $clog2(MAX + 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  cnt <= '0;
    else if (load)              cnt <= W'(MAX);
    else if (clr)               cnt <= '0;
    else if (en && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign last = (cnt == W'(1));
endmodule

// File: rtl/flash_cmd_datapath.sv
module flashCmdDatapath
  import flashCmdPkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int PROG_CYC  = 8,
  parameter int TO_CYC    = 20,
  parameter int ERASE_CYC = 60,
  parameter int SUSP_LAT  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busData,
  input  strobeT            stb,
  output logic              wrEv,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [7:0]        cmdData,
  output timerT             tmr,
  output logic [ADDR_W-1:0] progAddr,
  output logic [7:0]        progData,
  output logic [ADDR_W-1:0] eraseSector
);
  logic weQ;
  logic [ADDR_W-1:0] addrQ;
  logic leadEdge;

  assign leadEdge = busWe & ~weQ;
  assign wrEv     = ~busWe & weQ;
  assign cmdAddr  = addrQ;
  assign cmdData  = busData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weQ         <= 1'b0;
      addrQ       <= '0;
      progAddr    <= '0;
      progData    <= '0;
      eraseSector <= '0;
    end else begin
      weQ <= busWe;
      if (leadEdge)      addrQ       <= busAddr;
      if (stb.capProg) begin
        progAddr <= addrQ;
        progData <= busData;
      end
      if (stb.capSector) eraseSector <= addrQ;
    end
  end

  flashDownCnt #(.MAX(PROG_CYC)) u_progCnt (
    .clk(clk), .rstN(rstN), .load(stb.loadProg), .clr(1'b0), .en(1'b1),
    .last(tmr.progLast));

  flashDownCnt #(.MAX(TO_CYC)) u_toCnt (
    .clk(clk), .rstN(rstN), .load(stb.loadErase), .clr(stb.clrTo), .en(1'b1),
    .last(tmr.toLast));

  flashDownCnt #(.MAX(ERASE_CYC)) u_eraseCnt (
    .clk(clk), .rstN(rstN), .load(stb.loadErase), .clr(1'b0), .en(stb.runErase),
    .last(tmr.eraseLast));

  flashDownCnt #(.MAX(SUSP_LAT)) u_latCnt (
    .clk(clk), .rstN(rstN), .load(stb.loadLat), .clr(stb.clrLat), .en(stb.runErase),
    .last(tmr.latLast));
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flashCmdCtrl
  import flashCmdPkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEv,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [7:0]        cmdData,
  input  timerT             tmr,
  output strobeT            stb,
  output modeT              modeQ,
  output logic              progStart,
  output logic              eraseStart
);
  localparam logic [ADDR_W-1:0] ADR_A = ADDR_W'(UNLOCK_ADDR_A);
  localparam logic [ADDR_W-1:0] ADR_B = ADDR_W'(UNLOCK_ADDR_B);

  modeT modeNxt;
  seqT  seqQ, seqNxt;
  logic suspPendQ, suspPendNxt;
  logic progStartNxt, eraseStartNxt;
  logic hitA, hitB, inSusp;

  assign hitA   = (cmdAddr == ADR_A) && (cmdData == KEY_A);
  assign hitB   = (cmdAddr == ADR_B) && (cmdData == KEY_B);
  assign inSusp = (modeQ == MD_SUSP);

  always_comb begin
    modeNxt       = modeQ;
    seqNxt        = seqQ;
    suspPendNxt   = suspPendQ;
    stb           = '0;
    progStartNxt  = 1'b0;
    eraseStartNxt = 1'b0;
    case (modeQ)
      MD_PROG:      if (tmr.progLast) modeNxt = MD_READ;
      MD_SUSP_PROG: if (tmr.progLast) modeNxt = MD_SUSP;
      MD_ERASE_TO: begin
        if (wrEv && cmdData == OP_SUSPEND) begin
          modeNxt   = MD_SUSP;
          stb.clrTo = 1'b1;
        end else if (tmr.toLast) begin
          modeNxt       = MD_ERASE;
          eraseStartNxt = 1'b1;
        end
      end
      MD_ERASE: begin
        stb.runErase = 1'b1;
        if (tmr.eraseLast) begin
          modeNxt     = MD_READ;
          stb.clrLat  = 1'b1;
          suspPendNxt = 1'b0;
        end else if (suspPendQ && tmr.latLast) begin
          modeNxt     = MD_SUSP;
          suspPendNxt = 1'b0;
        end else if (wrEv && cmdData == OP_SUSPEND && !suspPendQ) begin
          stb.loadLat = 1'b1;
          suspPendNxt = 1'b1;
        end
      end
      MD_READ, MD_SUSP: begin
        if (wrEv) begin
          case (seqQ)
            SQ_IDLE: begin
              if (hitA) seqNxt = SQ_U1;
              else if (inSusp && cmdData == OP_RESUME) begin
                modeNxt       = MD_ERASE;
                eraseStartNxt = 1'b1;
              end
            end
            SQ_U1: seqNxt = hitB ? SQ_U2 : SQ_IDLE;
            SQ_U2: begin
              if (cmdAddr == ADR_A && cmdData == OP_PROG) seqNxt = SQ_PARM;
              else if (!inSusp && cmdAddr == ADR_A && cmdData == OP_ERASE_SET) seqNxt = SQ_E1;
              else seqNxt = SQ_IDLE;
            end
            SQ_PARM: begin
              seqNxt       = SQ_IDLE;
              modeNxt      = inSusp ? MD_SUSP_PROG : MD_PROG;
              stb.loadProg = 1'b1;
              stb.capProg  = 1'b1;
              progStartNxt = 1'b1;
            end
            SQ_E1: seqNxt = hitA ? SQ_E2 : SQ_IDLE;
            SQ_E2: seqNxt = hitB ? SQ_E3 : SQ_IDLE;
            SQ_E3: begin
              seqNxt = SQ_IDLE;
              if (cmdData == OP_SECTOR) begin
                modeNxt       = MD_ERASE_TO;
                stb.loadErase = 1'b1;
                stb.capSector = 1'b1;
              end
            end
            default: seqNxt = SQ_IDLE;
          endcase
        end
      end
      default: modeNxt = MD_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ      <= MD_READ;
      seqQ       <= SQ_IDLE;
      suspPendQ  <= 1'b0;
      progStart  <= 1'b0;
      eraseStart <= 1'b0;
    end else begin
      modeQ      <= modeNxt;
      seqQ       <= seqNxt;
      suspPendQ  <= suspPendNxt;
      progStart  <= progStartNxt;
      eraseStart <= eraseStartNxt;
    end
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flashCmdDecoder
  import flashCmdPkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int PROG_CYC  = 8,
  parameter int TO_CYC    = 20,
  parameter int ERASE_CYC = 60,
  parameter int SUSP_LAT  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busData,
  output logic [2:0]        mode,
  output logic              busy,
  output logic              progStart,
  output logic              eraseStart,
  output logic [ADDR_W-1:0] progAddr,
  output logic [7:0]        progData,
  output logic [ADDR_W-1:0] eraseSector
);
  strobeT            stb;
  timerT             tmr;
  modeT              modeQ;
  logic              wrEv;
  logic [ADDR_W-1:0] cmdAddr;
  logic [7:0]        cmdData;

  flashCmdDatapath #(
    .ADDR_W(ADDR_W), .PROG_CYC(PROG_CYC), .TO_CYC(TO_CYC),
    .ERASE_CYC(ERASE_CYC), .SUSP_LAT(SUSP_LAT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busData(busData),
    .stb(stb), .wrEv(wrEv), .cmdAddr(cmdAddr), .cmdData(cmdData), .tmr(tmr),
    .progAddr(progAddr), .progData(progData), .eraseSector(eraseSector));

  flashCmdCtrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEv(wrEv), .cmdAddr(cmdAddr), .cmdData(cmdData),
    .tmr(tmr), .stb(stb), .modeQ(modeQ), .progStart(progStart),
    .eraseStart(eraseStart));

  assign mode = modeQ;
  assign busy = (modeQ == MD_PROG) || (modeQ == MD_ERASE_TO) ||
                (modeQ == MD_ERASE) || (modeQ == MD_SUSP_PROG);
endmodule

// File: rtl/flash_cmd_chk.sv
module flashCmdChk (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] mode,
  input logic       busy,
  input logic       progStart,
  input logic       eraseStart
);
  // R2: a program start pulse only comes with a programming mode
  p_prog_pulse_mode_r2: assert property (@(posedge clk) disable iff (!rstN)
    progStart |-> (mode == 3'd1 || mode == 3'd5))
    else $error("p_prog_pulse_mode_r2");

  // R10: an erase start pulse only comes with the erasing mode
  p_erase_pulse_mode_r10: assert property (@(posedge clk) disable iff (!rstN)
    eraseStart |-> (mode == 3'd3 && busy))
    else $error("p_erase_pulse_mode_r10");

  // R6: suspended is entered only from the erase time-out or erasing
  p_susp_entry_r6: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'd4 && $past(mode) != 3'd4 && $past(mode) != 3'd5) |->
      ($past(mode) == 3'd2 || $past(mode) == 3'd3))
    else $error("p_susp_entry_r6");

  // R11: a program in suspend hands back to suspended
  p_susp_prog_exit_r11: assert property (@(posedge clk) disable iff (!rstN)
    ($past(mode) == 3'd5 && mode != 3'd5) |-> mode == 3'd4)
    else $error("p_susp_prog_exit_r11");

  // R3: a normal program hands back to read
  p_prog_exit_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(mode) == 3'd1 && mode != 3'd1) |-> mode == 3'd0)
    else $error("p_prog_exit_r3");

  // R12: suspended is never busy
  p_susp_idle_r12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mode == 3'd4) |-> !busy)
    else $error("p_susp_idle_r12");
endmodule

bind flashCmdDecoder flashCmdChk u_chk (
  .clk(clk), .rstN(rstN), .mode(mode), .busy(busy),
  .progStart(progStart), .eraseStart(eraseStart));

// File: tb/flashCmdDecoder_tb.sv
`timescale 1ns/1ps
module flashCmdDecoder_tb;
  localparam int ADDR_W    = 11;
  localparam int PROG_CYC  = 8;
  localparam int TO_CYC    = 20;
  localparam int ERASE_CYC = 60;
  localparam int SUSP_LAT  = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWe = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [7:0] busData = '0;
  logic [2:0] mode;
  logic busy, progStart, eraseStart;
  logic [ADDR_W-1:0] progAddr, eraseSector;
  logic [7:0] progData;

  int nTests = 0;
  int nFail  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  flashCmdDecoder #(
    .ADDR_W(ADDR_W), .PROG_CYC(PROG_CYC), .TO_CYC(TO_CYC),
    .ERASE_CYC(ERASE_CYC), .SUSP_LAT(SUSP_LAT)
  ) u_dut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busData(busData),
    .mode(mode), .busy(busy), .progStart(progStart), .eraseStart(eraseStart),
    .progAddr(progAddr), .progData(progData), .eraseSector(eraseSector));

  // ---------------- behavioural reference model ----------------
  int mMode, mStep, mProgLeft, mToLeft, mEraseLeft, mLatLeft;
  int mAddrHeld, mProgAddr, mProgData, mSector;
  bit mPrevWe, mPs, mEs;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mMode = 0; mStep = 0; mProgLeft = 0; mToLeft = 0; mEraseLeft = 0;
      mLatLeft = 0; mAddrHeld = 0; mProgAddr = 0; mProgData = 0; mSector = 0;
      mPrevWe = 0; mPs = 0; mEs = 0;
    end else begin
      automatic bit wrote = mPrevWe && !busWe;
      automatic int d = int'(busData);
      automatic int a = mAddrHeld;
      automatic bit keyA = (a == 'h555) && (d == 'hAA);
      automatic bit keyB = (a == 'h2AA) && (d == 'h55);
      automatic int nProg = (mProgLeft > 0) ? mProgLeft - 1 : 0;
      automatic int nTo   = (mToLeft > 0) ? mToLeft - 1 : 0;
      automatic int nEr   = (mMode == 3 && mEraseLeft > 0) ? mEraseLeft - 1 : mEraseLeft;
      automatic int nLat  = (mMode == 3 && mLatLeft > 0) ? mLatLeft - 1 : mLatLeft;
      mPs = 0; mEs = 0;
      if (mMode == 1 || mMode == 5) begin
        if (mProgLeft == 1) mMode = (mMode == 1) ? 0 : 4;
      end else if (mMode == 2) begin
        if (wrote && d == 'hB0) begin mMode = 4; nTo = 0; end
        else if (mToLeft == 1) begin mMode = 3; mEs = 1; end
      end else if (mMode == 3) begin
        if (mEraseLeft == 1) begin mMode = 0; nLat = 0; end
        else if (mLatLeft == 1) mMode = 4;
        else if (wrote && d == 'hB0 && mLatLeft == 0) nLat = SUSP_LAT;
      end else if (wrote) begin
        if (mStep == 0) begin
          if (keyA) mStep = 1;
          else if (mMode == 4 && d == 'h30) begin mMode = 3; mEs = 1; end
        end else if (mStep == 1 || mStep == 5) begin
          mStep = keyB ? mStep + 1 : 0;
        end else if (mStep == 4) begin
          mStep = keyA ? 5 : 0;
        end else if (mStep == 2) begin
          if (a == 'h555 && d == 'hA0) mStep = 3;
          else if (mMode == 0 && a == 'h555 && d == 'h80) mStep = 4;
          else mStep = 0;
        end else if (mStep == 3) begin
          mStep = 0; mPs = 1; nProg = PROG_CYC;
          mProgAddr = a; mProgData = d;
          mMode = (mMode == 4) ? 5 : 1;
        end else begin
          mStep = 0;
          if (d == 'h30) begin
            mMode = 2; nTo = TO_CYC; nEr = ERASE_CYC; mSector = a;
          end
        end
      end
      mProgLeft = nProg; mToLeft = nTo; mEraseLeft = nEr; mLatLeft = nLat;
      if (!mPrevWe && busWe) mAddrHeld = int'(busAddr);
      mPrevWe = busWe;
    end
  end

  // ---------------- reporting ----------------
  task automatic chk(input string tag, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison with the reference model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      automatic int bad = 0;
      automatic bit expBusy = (mMode == 1 || mMode == 2 || mMode == 3 || mMode == 5);
      nTests++;
      if (int'(mode) != mMode) begin bad++; $display("FAIL model R3 mode actual=%0d expected=%0d at %0t", mode, mMode, $time); end
      if (busy != expBusy) begin bad++; $display("FAIL model R12 busy actual=%0d expected=%0d at %0t", busy, expBusy, $time); end
      if (progStart != mPs) begin bad++; $display("FAIL model R2 progStart actual=%0d expected=%0d at %0t", progStart, mPs, $time); end
      if (eraseStart != mEs) begin bad++; $display("FAIL model R10 eraseStart actual=%0d expected=%0d at %0t", eraseStart, mEs, $time); end
      if (int'(progAddr) != mProgAddr || int'(progData) != mProgData) begin
        bad++; $display("FAIL model R2 prog actual=%0h/%0h expected=%0h/%0h at %0t", progAddr, progData, mProgAddr, mProgData, $time);
      end
      if (int'(eraseSector) != mSector) begin bad++; $display("FAIL model R5 sector actual=%0h expected=%0h at %0t", eraseSector, mSector, $time); end
      if (bad != 0) nFail++;
    end
  end

  // one bus write: strobe high one cycle, low again; returns after the acting edge
  task automatic wr(input int a, input int d);
    @(negedge clk); busAddr = ADDR_W'(a); busData = 8'(d); busWe = 1'b1;
    @(negedge clk); busWe = 1'b0;
    @(negedge clk);
  endtask

  task automatic progSeq(input int a, input int d);
    wr('h555, 'hAA); wr('h2AA, 'h55); wr('h555, 'hA0); wr(a, d);
  endtask

  task automatic eraseSeq(input int sec);
    wr('h555, 'hAA); wr('h2AA, 'h55); wr('h555, 'h80);
    wr('h555, 'hAA); wr('h2AA, 'h55); wr(sec, 'h30);
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 mode", mode, 0); chk("R1 busy", busy, 0);
    chk("R1 pulses", {progStart, eraseStart}, 0);

    // R2: program sequence
    progSeq('h123, 'h3C);
    chk("R2 mode", mode, 1); chk("R2 progStart", progStart, 1);
    chk("R2 progAddr", progAddr, 'h123); chk("R2 progData", progData, 'h3C);
    chk("R12 busy in program", busy, 1);
    // R13: a write during programming is ignored
    wr('h000, 'hB0);
    chk("R13 mode", mode, 1);
    repeat (PROG_CYC - 4) @(negedge clk);
    chk("R3 still programming", mode, 1);
    @(negedge clk);
    chk("R3 back to read", mode, 0);

    // R4: mismatched unlock resets the sequence
    wr('h555, 'hAA); wr('h111, 'h55); wr('h555, 'hA0); wr('h200, 'h77);
    chk("R4 mode", mode, 0); chk("R4 progData", progData, 'h3C);

    // R8: suspend and resume bytes in read mode
    wr('h000, 'hB0); chk("R8 suspend in read", mode, 0);
    wr('h000, 'h30); chk("R8 resume in read", mode, 0);

    // R5: sector erase, time-out, erase, done
    eraseSeq('h3C0);
    chk("R5 time-out", mode, 2); chk("R5 sector", eraseSector, 'h3C0);
    repeat (TO_CYC - 1) @(negedge clk);
    chk("R5 time-out end", mode, 2);
    @(negedge clk);
    chk("R5 erasing", mode, 3); chk("R5 eraseStart", eraseStart, 1);
    repeat (ERASE_CYC - 1) @(negedge clk);
    chk("R5 erase end", mode, 3);
    @(negedge clk);
    chk("R5 read", mode, 0);

    // R6: suspend in time-out is immediate
    eraseSeq('h100);
    wr('h000, 'hB0);
    chk("R6 suspended", mode, 4); chk("R12 suspended idle", busy, 0);
    // R9: only resume and program act while suspended
    wr('h555, 'hAA); wr('h2AA, 'h55); wr('h555, 'h80);
    chk("R9 erase seq ignored", mode, 4);
    wr('h000, 'hB0);
    chk("R9 suspend ignored", mode, 4);
    // R10: resume
    wr('h000, 'h30);
    chk("R10 resumed", mode, 3); chk("R10 eraseStart", eraseStart, 1);

    // R7: suspend while erasing after a latency
    wr('h000, 'hB0);
    repeat (SUSP_LAT - 1) @(negedge clk);
    chk("R7 still erasing", mode, 3);
    @(negedge clk);
    chk("R7 suspended", mode, 4);

    // R11: program in suspend
    progSeq('h0AB, 'h5A);
    chk("R11 mode", mode, 5); chk("R11 progData", progData, 'h5A);
    repeat (PROG_CYC - 1) @(negedge clk);
    chk("R11 still programming", mode, 5);
    @(negedge clk);
    chk("R11 back to suspended", mode, 4);

    // R10: repeated suspend and resume, then completion
    wr('h000, 'h30); chk("R10 resume again", mode, 3);
    wr('h000, 'hB0);
    repeat (SUSP_LAT) @(negedge clk);
    chk("R10 suspended again", mode, 4);
    wr('h000, 'h30); chk("R10 third resume", mode, 3);
    for (int i = 0; i < 200 && mode != 3'd0; i++) @(negedge clk);
    chk("R10 erase completes", mode, 0);

    // R7: suspend issued too late, erase ends first
    eraseSeq('h080);
    repeat (TO_CYC + ERASE_CYC - 5) @(negedge clk);
    wr('h000, 'hB0);
    repeat (SUSP_LAT + 2) @(negedge clk);
    chk("R7 erase end wins", mode, 0);

    repeat (4) @(negedge clk);
    summary();
  end
endmodule